// File: doc/BRIEF.md
# Paged Result Write Controller

This block moves captured response vectors from a tester-side output buffer into an external result memory, one page at a time. It waits until the destination page is reported available, waits a fixed settling delay, loads a per-page word counter and then copies words one by one. Each word is popped from the buffer in the same cycle that the memory accepts it. When a full page has been written it raises a one-cycle completion pulse and goes back to wait for the next page. A page is never written twice: there is no replay path.

The buffer is first-word-fall-through. While it is not empty, its head word is on `buf_data`, and a pop takes that word. The memory port is a request/accept pair. A write happens in any cycle where `mem_req` and `mem_ack` are both high. Addresses start at `PAGE_BASE` and run on without a break across pages. Page N therefore starts at `PAGE_BASE + N*PAGE_WORDS`.

States and transitions:

| State | Leaves when | Goes to |
|---|---|---|
| IDLE | always, after reset | CHECK |
| CHECK | `page_avail` high | ENTER |
| ENTER | always; loads the delay counter | DELAY |
| DELAY | `DELAY_CYC` cycles have passed | INIT |
| INIT | always; loads the word counter with `PAGE_WORDS` | WRITE |
| WRITE | the last word of the page is accepted | FINISH |
| FINISH | always; pulses `page_done` | CHECK |

Top module: `pgwr_ctrl`

## Requirements
- R1: While `rst_n` is low, `mem_req`, `buf_pop` and `page_done` are 0 and `mem_addr` equals `PAGE_BASE`.
- R2: No write and no pop happens until `page_avail` is sampled high in the CHECK state. Buffered words stay in the buffer while availability is low.
- R3: The first request of a page can appear no sooner than after the (DELAY_CYC+3)th rising edge, counting the edge that samples `page_avail` high as the first. With a non-empty buffer it appears exactly then.
- R4: `mem_req` is high only in WRITE and only while `buf_empty` is 0. `mem_wdata` carries the buffer head word.
- R5: A word transfers only in a cycle where `mem_req` and `mem_ack` are both high, and `buf_pop` is high in exactly that cycle. Without acceptance, the address and the remaining count hold.
- R6: After reset the first accepted word goes to `PAGE_BASE`. Each accepted word raises the address by one, and this continues across page boundaries.
- R7: After `PAGE_WORDS` accepted words, `page_done` is high for exactly one cycle. In that cycle `mem_req` and `buf_pop` are 0.
- R8: After `page_done` the controller returns to CHECK. With `page_avail` low it writes nothing more, even if the buffer holds words.
- R9: `page_avail` is only looked at in CHECK. Dropping it during a page does not stop that page from finishing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| page_avail | input | 1 | Destination page is free to be written |
| buf_empty | input | 1 | Output buffer holds no word |
| buf_data | input | DATA_W | Head word of the output buffer |
| buf_pop | output | 1 | Remove the head word from the buffer |
| mem_addr | output | ADDR_W | Result memory write address |
| mem_wdata | output | DATA_W | Result memory write data |
| mem_req | output | 1 | Write request |
| mem_ack | input | 1 | Memory accepts the request this cycle |
| page_done | output | 1 | One-cycle pulse when a page is complete |

## Verification
The checker watches every cycle for the following:
- a request raised against an empty buffer;
- a pop without an accepted write;
- an address that moves during a refused request, or that moves by anything other than one on acceptance;
- a completion pulse longer than one cycle, or one that overlaps a request.

Other properties only the directed scenarios can show:
- the exact start latency after availability;
- that nothing is written while availability is low;
- that every captured word lands at its expected address in order across pages, under memory back-pressure and under a starving buffer;
- that no page is replayed.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CHECK  = 3'd1,
        ST_ENTER  = 3'd2,
        ST_DELAY  = 3'd3,
        ST_INIT   = 3'd4,
        ST_WRITE  = 3'd5,
        ST_FINISH = 3'd6
    } pgwr_state_t;

endpackage

// File: rtl/pgwr_fsm.sv
module pgwr_fsm
    import pgwr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic page_avail,
    input  logic delay_done,
    input  logic last_word,
    output logic ld_delay,
    output logic run_delay,
    output logic ld_count,
    output logic wr_phase,
    output logic done_pulse
);

    pgwr_state_t state_q;
    pgwr_state_t state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = ST_CHECK;
            ST_CHECK:  if (page_avail) state_d = ST_ENTER;
            ST_ENTER:  state_d = ST_DELAY;
            ST_DELAY:  if (delay_done) state_d = ST_INIT;
            ST_INIT:   state_d = ST_WRITE;
            ST_WRITE:  if (last_word) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_CHECK;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state decodes
    always_comb begin
        ld_delay   = 1'b0;
        run_delay  = 1'b0;
        ld_count   = 1'b0;
        wr_phase   = 1'b0;
        done_pulse = 1'b0;
        unique case (state_q)
            ST_ENTER:  ld_delay   = 1'b1;
            ST_DELAY:  run_delay  = 1'b1;
            ST_INIT:   ld_count   = 1'b1;
            ST_WRITE:  wr_phase   = 1'b1;
            ST_FINISH: done_pulse = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/pgwr_delay.sv
module pgwr_delay #(
    parameter int DELAY_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic done
);

    localparam int DW = (DELAY_CYC > 1) ? $clog2(DELAY_CYC) : 1;
    localparam logic [DW-1:0] LOAD_VAL = DW'(DELAY_CYC - 1);

    logic [DW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= LOAD_VAL;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // the DELAY state lasts DELAY_CYC cycles: it leaves when the count is zero
    assign done = run && (cnt_q == '0);

endmodule

// File: rtl/pgwr_wordcnt.sv
module pgwr_wordcnt #(
    parameter int              ADDR_W     = 16,
    parameter int              PAGE_WORDS = 8,
    parameter logic [ADDR_W-1:0] PAGE_BASE = 'h100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              fire,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);

    localparam int CW = $clog2(PAGE_WORDS + 1);
    localparam logic [CW-1:0] FULL = CW'(PAGE_WORDS);

    logic [CW-1:0]     remain_q;
    logic [ADDR_W-1:0] addr_q;

    // words left in the current page
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= FULL;
        end else if (fire && (remain_q != '0)) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    // running write address, continuous across pages
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= PAGE_BASE;
        end else if (fire) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    assign addr = addr_q;
    assign last = fire && (remain_q == CW'(1));

endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl #(
    parameter int                ADDR_W     = 16,
    parameter int                DATA_W     = 32,
    parameter int                PAGE_WORDS = 8,
    parameter int                DELAY_CYC  = 3,
    parameter logic [ADDR_W-1:0] PAGE_BASE  = 'h100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              page_avail,
    input  logic              buf_empty,
    input  logic [DATA_W-1:0] buf_data,
    output logic              buf_pop,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_req,
    input  logic              mem_ack,
    output logic              page_done
);

    logic ld_delay;
    logic run_delay;
    logic ld_count;
    logic wr_phase;
    logic delay_done;
    logic last_word;
    logic fire;

    pgwr_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .page_avail (page_avail),
        .delay_done (delay_done),
        .last_word  (last_word),
        .ld_delay   (ld_delay),
        .run_delay  (run_delay),
        .ld_count   (ld_count),
        .wr_phase   (wr_phase),
        .done_pulse (page_done)
    );

    pgwr_delay #(
        .DELAY_CYC (DELAY_CYC)
    ) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ld_delay),
        .run   (run_delay),
        .done  (delay_done)
    );

    pgwr_wordcnt #(
        .ADDR_W     (ADDR_W),
        .PAGE_WORDS (PAGE_WORDS),
        .PAGE_BASE  (PAGE_BASE)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ld_count),
        .fire  (fire),
        .addr  (mem_addr),
        .last  (last_word)
    );

    assign mem_req   = wr_phase && !buf_empty;
    assign fire      = mem_req && mem_ack;
    assign buf_pop   = fire;
    assign mem_wdata = buf_data;

endmodule

// File: rtl/pgwr_ctrl_chk.sv
module pgwr_ctrl_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              buf_empty,
    input logic              buf_pop,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              page_done
);

    // R4: never request against an empty buffer
    a_r4_req_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !buf_empty);

    // R5: a pop only accompanies an accepted write
    a_r5_pop_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        buf_pop |-> (mem_req && mem_ack));

    // R5: a refused request keeps its address
    a_r5_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> $stable(mem_addr));

    // R6: an accepted word moves the address by one
    a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

    // R7: completion is a single quiet cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        page_done |=> !page_done);

    a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        page_done |-> (!mem_req && !buf_pop));

    // R8: after completion the controller is back in the check state, not writing
    a_r8_no_req_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        page_done |=> !mem_req);

    // R1: outputs quiet in reset
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_quiet: assert (!mem_req && !buf_pop && !page_done);
        end
    end

endmodule

bind pgwr_ctrl pgwr_ctrl_chk #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .buf_empty (buf_empty),
    .buf_pop   (buf_pop),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .page_done (page_done)
);

// File: tb/pgwr_ctrl_bench.sv
module pgwr_ctrl_bench;

    localparam int          CLK_PERIOD = 10;
    localparam int          AW   = 16;
    localparam int          DW   = 32;
    localparam int          PW   = 8;
    localparam int          DC   = 3;
    localparam logic [15:0] BASE = 16'h0100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          page_avail = 1'b0;
    logic          buf_empty;
    logic [DW-1:0] buf_data;
    logic          buf_pop;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_req;
    logic          mem_ack;
    logic          page_done;

    logic [6:0]    src_wr = '0;
    logic [6:0]    src_rd;
    logic          ack_throttle = 1'b0;
    int            cyc = 0;
    int            log_n;
    int            done_n;
    logic [AW-1:0] log_addr [0:63];
    logic [DW-1:0] log_data [0:63];
    int            checks = 0;
    int            errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgwr_ctrl #(
        .ADDR_W     (AW),
        .DATA_W     (DW),
        .PAGE_WORDS (PW),
        .DELAY_CYC  (DC),
        .PAGE_BASE  (BASE)
    ) u_pgwr_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .page_avail (page_avail),
        .buf_empty  (buf_empty),
        .buf_data   (buf_data),
        .buf_pop    (buf_pop),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_req    (mem_req),
        .mem_ack    (mem_ack),
        .page_done  (page_done)
    );

    // buffer model: word i holds A500_0000 + i
    assign buf_empty = (src_rd == src_wr);
    assign buf_data  = 32'hA500_0000 | {25'd0, src_rd};
    // memory model: accept always, or one cycle in four when throttled
    assign mem_ack   = !ack_throttle || (cyc[1:0] == 2'b11);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            src_rd <= '0;
            log_n  <= 0;
            done_n <= 0;
        end else begin
            if (buf_pop) src_rd <= src_rd + 1'b1;
            if (mem_req && mem_ack && log_n < 64) begin
                log_addr[log_n] <= mem_addr;
                log_data[log_n] <= mem_wdata;
                log_n <= log_n + 1;
            end
            if (page_done) done_n <= done_n + 1;
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc == 20000) begin
            checks++;
            errors++;
            $display("FAIL R8 watchdog actual=%0d expected<%0d cycles", cyc, 20000);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_done();
        while (!page_done) @(negedge clk);
    endtask

    task automatic check_page(input int p);
        for (int i = 0; i < PW; i++) begin
            int idx = p * PW + i;
            chk(log_addr[idx] == AW'(BASE + idx), "R6 address", log_addr[idx], BASE + idx);
            chk(log_data[idx] == (32'hA500_0000 + idx), "R4 data order", log_data[idx],
                32'hA500_0000 + idx);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!mem_req && !buf_pop && !page_done, "R1 outputs quiet",
            {mem_req, buf_pop, page_done}, 0);
        chk(mem_addr == BASE, "R1 address", mem_addr, BASE);
        rst_n = 1'b1;
    endtask

    task automatic t_gate();
        src_wr = 7'd8;
        repeat (20) @(negedge clk);
        chk(log_n == 0, "R2 no write while unavailable", log_n, 0);
        chk(src_rd == 0, "R2 buffer untouched", src_rd, 0);
    endtask

    task automatic t_delay_first_page();
        int k = 0;
        page_avail = 1'b1;
        do begin
            @(posedge clk);
            k++;
            @(negedge clk);
        end while (!mem_req && k < 50);
        chk(k == DC + 3, "R3 start latency", k, DC + 3);
        wait_done();
        chk(!mem_req && !buf_pop, "R7 finish quiet", {mem_req, buf_pop}, 0);
        page_avail = 1'b0;
        @(negedge clk);
        chk(!page_done, "R7 single pulse", page_done, 0);
        chk(done_n == 1, "R7 one pulse", done_n, 1);
        chk(log_n == PW, "R7 page length", log_n, PW);
        check_page(0);
    endtask

    task automatic t_no_replay();
        src_wr = 7'd16;
        repeat (20) @(negedge clk);
        chk(log_n == PW, "R8 no further writes", log_n, PW);
        chk(src_rd == 7'd8, "R8 buffer kept", src_rd, 8);
    endtask

    task automatic t_backpressure();
        ack_throttle = 1'b1;
        page_avail = 1'b1;
        wait_done();
        page_avail = 1'b0;
        @(negedge clk);
        ack_throttle = 1'b0;
        chk(log_n == 2 * PW, "R5 words under stall", log_n, 2 * PW);
        chk(done_n == 2, "R7 second pulse", done_n, 2);
        check_page(1);
    endtask

    task automatic t_starved_and_drop();
        page_avail = 1'b1;
        for (int i = 0; i < PW; i++) begin
            repeat (4) @(negedge clk);
            chk(!mem_req, "R4 no request when empty", mem_req, 0);
            src_wr = src_wr + 1'b1;
            if (i == 1) page_avail = 1'b0;
        end
        wait_done();
        @(negedge clk);
        chk(log_n == 3 * PW, "R9 page completes after drop", log_n, 3 * PW);
        chk(src_rd == 7'd24, "R5 pops match writes", src_rd, 24);
        chk(done_n == 3, "R9 third pulse", done_n, 3);
        check_page(2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_gate();
        t_delay_first_page();
        t_no_replay();
        t_backpressure();
        t_starved_and_drop();
        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule